// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Sequencer

This block holds the two threshold offsets that the partial-flag logic of a dual-clock FIFO compares against. The almost-empty offset and the almost-full offset each occupy three byte-wide registers, so there are six registers in all. Software or a controller reaches them one word at a time through the FIFO's own data buses. A load strobe, driven low, steers accesses away from the FIFO memory and into the offset registers.

Writes happen on the write clock and are addressed by a write pointer. Reads happen on the read clock and are addressed by a separate read pointer. Both pointers move through the six registers in a fixed order and wrap back to the start after the last one. Either sequence can be paused and later picked up at the next register. While a pause lasts, ordinary FIFO traffic can use the same buses.

The block also reports, for each partial flag, whether that flag's offset is complete. The neighbouring comparator can then ignore a flag while its offset is only partly written.

Top module: `ofs_seq`

## Requirements
- R1: On a write-clock rising edge with `ld_n`=0 and `wen_n`=0, `din` is stored into the register picked by the write pointer, and the pointer advances by one.
- R2: Register index 0, 1 and 2 hold the almost-empty offset, from least significant byte up to most significant byte (`empty_ofs[7:0]` is index 0). Index 3, 4 and 5 hold the almost-full offset in the same byte order. Both pointers go from index 5 back to index 0.
- R3: On a read-clock rising edge with `ld_n`=0 and `ren_n`=0, `dout` takes the register picked by the read pointer, and the read pointer advances. It uses the same order and wrap as R2.
- R4: On a read-clock rising edge with `ld_n`=1 and `ren_n`=0, `dout` takes the FIFO word `mem_q`. An offset read therefore replaces whatever FIFO word was on `dout`.
- R5: If `ld_n`=1 or the matching enable is 1, that side's pointer does not move. In the same case the write side leaves the offsets unchanged and the read side leaves `dout` unchanged, unless R4 applies. A later access resumes at the next register in order.
- R6: The two pointers are independent. Write-domain reset `wrst` clears only the write pointer and restores the offsets. Read-domain reset `rrst` clears only the read pointer and `dout`.
- R7: `paf_valid` goes low in the cycle after a write to index 3 or 4. It goes high two write-clock edges after the edge that writes index 5.
- R8: `pae_valid` follows almost-empty completeness through two read-clock stages. It goes low two read-clock edges after a write to index 0 or 1. It goes high two read-clock edges after the edge that writes index 2.
- R9: An offset write and an offset read must never occur in the same cycle.
- R10: After reset the offsets equal `EMPTY_INIT` and `FULL_INIT`, and both valid flags go high two edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst | input | 1 | Synchronous active-high master reset, write domain |
| ld_n | input | 1 | Load strobe, low selects the offset registers |
| wen_n | input | 1 | Write enable, active low |
| din | input | W | Write data bus |
| rclk | input | 1 | Read clock |
| rrst | input | 1 | Synchronous active-high master reset, read domain |
| ren_n | input | 1 | Read enable, active low |
| mem_q | input | W | Word delivered by the FIFO memory |
| dout | output | W | Registered output data bus |
| empty_ofs | output | NB*W | Almost-empty offset for the comparator |
| full_ofs | output | NB*W | Almost-full offset for the comparator |
| pae_valid | output | 1 | Almost-empty offset complete, read domain |
| paf_valid | output | 1 | Almost-full offset complete, write domain |

## Verification
The checker evaluates the strobe and both enables on the write clock. It therefore assumes that the two clocks are aligned, and it treats an offset write together with an offset read as a broken input rule, not a design fault. The bench drives both clock ports from one 250 MHz clock. It picks at most one operation per cycle, so offset writes and offset reads never coincide, while FIFO-side traffic is interleaved freely. Each reset is applied to both domains together, so the assertions never see one domain in reset while the other is running.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // advance a register index, wrapping at n
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/ofs_wrap_ptr.sv
module ofs_wrap_ptr #(
  parameter int N  = 6,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (step) ptr <= PW'(ofs_pkg::wrap_next(32'(ptr), N));
  end
endmodule

// File: rtl/ofs_bank.sv
module ofs_bank #(
  parameter int W  = 8,
  parameter int NB = 3,
  parameter logic [NB*W-1:0] INIT_LO = '0,
  parameter logic [NB*W-1:0] INIT_HI = '0,
  localparam int NREG = 2*NB,
  localparam int PW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PW-1:0]   sel,
  input  logic [W-1:0]    wdata,
  output logic [NREG*W-1:0] all_bytes,
  output logic [1:0]      done
);
  localparam logic [NREG*W-1:0] INIT_ALL = {INIT_HI, INIT_LO};

  logic [W-1:0] bq [NREG];

  // one byte register per index, reset to its share of the defaults
  for (genvar g = 0; g < NREG; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                          bq[g] <= INIT_ALL[g*W +: W];
      else if (we && sel == PW'(g))     bq[g] <= wdata;
    end
    assign all_bytes[g*W +: W] = bq[g];
  end

  // completeness per offset: cleared by a lower byte, set by the top byte
  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int unsigned BASE = s*NB;
    logic in_side;
    assign in_side = (32'(sel) >= BASE) && (32'(sel) < BASE + NB);
    always_ff @(posedge clk) begin
      if (rst)                 done[s] <= 1'b1;
      else if (we && in_side)  done[s] <= (32'(sel) == BASE + NB - 1);
    end
  end
endmodule

// File: rtl/ofs_valid_pipe.sv
module ofs_valid_pipe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end
  assign q = sh[STAGES-1];
endmodule

// File: rtl/ofs_seq.sv
module ofs_seq #(
  parameter int W   = 8,
  parameter int NB  = 3,
  parameter int LAT = 2,
  parameter logic [NB*W-1:0] EMPTY_INIT = 'h40,
  parameter logic [NB*W-1:0] FULL_INIT  = 'h40
) (
  input  logic            wclk,
  input  logic            wrst,
  input  logic            ld_n,
  input  logic            wen_n,
  input  logic [W-1:0]    din,
  input  logic            rclk,
  input  logic            rrst,
  input  logic            ren_n,
  input  logic [W-1:0]    mem_q,
  output logic [W-1:0]    dout,
  output logic [NB*W-1:0] empty_ofs,
  output logic [NB*W-1:0] full_ofs,
  output logic            pae_valid,
  output logic            paf_valid
);
  localparam int NREG = 2*NB;
  localparam int PW   = $clog2(NREG);

  logic              wr_hit, rd_hit;
  logic [PW-1:0]     wptr, rptr;
  logic [NREG*W-1:0] all_bytes;
  logic [1:0]        done;
  logic              paf_late;

  assign wr_hit = !ld_n && !wen_n;
  assign rd_hit = !ld_n && !ren_n;

  ofs_wrap_ptr #(.N(NREG), .PW(PW)) u_wptr (
    .clk(wclk), .rst(wrst), .step(wr_hit), .ptr(wptr));

  ofs_wrap_ptr #(.N(NREG), .PW(PW)) u_rptr (
    .clk(rclk), .rst(rrst), .step(rd_hit), .ptr(rptr));

  ofs_bank #(.W(W), .NB(NB), .INIT_LO(EMPTY_INIT), .INIT_HI(FULL_INIT)) u_bank (
    .clk(wclk), .rst(wrst), .we(wr_hit), .sel(wptr), .wdata(din),
    .all_bytes(all_bytes), .done(done));

  assign empty_ofs = all_bytes[0 +: NB*W];
  assign full_ofs  = all_bytes[NB*W +: NB*W];

  // almost-full completeness stays in the write domain
  ofs_valid_pipe #(.STAGES(LAT)) u_paf (
    .clk(wclk), .rst(wrst), .d(done[1]), .q(paf_late));
  assign paf_valid = paf_late & done[1];

  // almost-empty completeness crosses to the read domain
  ofs_valid_pipe #(.STAGES(LAT)) u_pae (
    .clk(rclk), .rst(rrst), .d(done[0]), .q(pae_valid));

  // output bus: FIFO word or offset byte
  always_ff @(posedge rclk) begin
    if (rrst)        dout <= '0;
    else if (!ren_n) dout <= ld_n ? mem_q : all_bytes[int'(rptr)*W +: W];
  end
endmodule

// File: rtl/ofs_seq_chk.sv
module ofs_seq_chk #(
  parameter int W  = 8,
  parameter int NB = 3,
  localparam int NREG = 2*NB,
  localparam int PW   = $clog2(NREG)
) (
  input logic            wclk,
  input logic            rclk,
  input logic            wrst,
  input logic            rrst,
  input logic            ld_n,
  input logic            wen_n,
  input logic            ren_n,
  input logic [PW-1:0]   wptr,
  input logic [PW-1:0]   rptr,
  input logic [W-1:0]    dout,
  input logic [NB*W-1:0] empty_ofs,
  input logic [NB*W-1:0] full_ofs,
  input logic            paf_valid
);
  localparam logic [PW-1:0] LAST = PW'(NREG-1);
  localparam logic [PW-1:0] FULL_LO = PW'(NB);

  p_wr_advance_r1: assert property (@(posedge wclk) disable iff (wrst)
    (!ld_n && !wen_n && wptr != LAST) |=> (wptr == $past(wptr) + 1'b1));

  p_wr_wrap_r2: assert property (@(posedge wclk) disable iff (wrst)
    (!ld_n && !wen_n && wptr == LAST) |=> (wptr == '0));

  p_rd_wrap_r3: assert property (@(posedge rclk) disable iff (rrst)
    (!ld_n && !ren_n && rptr == LAST) |=> (rptr == '0));

  p_wr_pause_r5: assert property (@(posedge wclk) disable iff (wrst)
    (ld_n || wen_n) |=> ($stable(wptr) && $stable(empty_ofs) && $stable(full_ofs)));

  p_rd_pause_r5: assert property (@(posedge rclk) disable iff (rrst)
    ren_n |=> ($stable(dout) && $stable(rptr)));

  p_rd_fifo_r4: assert property (@(posedge rclk) disable iff (rrst)
    (ld_n && !ren_n) |=> $stable(rptr));

  p_paf_drop_r7: assert property (@(posedge wclk) disable iff (wrst)
    (!ld_n && !wen_n && wptr == FULL_LO) |=> !paf_valid);

  // input rule, meaningful with aligned clocks
  p_no_collide_r9: assert property (@(posedge wclk) disable iff (wrst)
    !(!ld_n && !wen_n && !ren_n));
endmodule

bind ofs_seq ofs_seq_chk #(.W(W), .NB(NB)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst(wrst), .rrst(rrst),
  .ld_n(ld_n), .wen_n(wen_n), .ren_n(ren_n),
  .wptr(wptr), .rptr(rptr), .dout(dout),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs), .paf_valid(paf_valid));

// File: tb/sim_ofs_seq.sv
module sim_ofs_seq;
  localparam int W = 8;
  localparam int NB = 3;
  localparam logic [23:0] EINIT = 24'h000040;
  localparam logic [23:0] FINIT = 24'h000040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_n = 1'b1, wen_n = 1'b1, ren_n = 1'b1;
  logic [7:0] din = '0, mem_q = '0;
  logic [7:0] dout;
  logic [23:0] empty_ofs, full_ofs;
  logic pae_valid, paf_valid;

  always #2 clk = ~clk;

  ofs_seq #(.W(W), .NB(NB), .LAT(2), .EMPTY_INIT(EINIT), .FULL_INIT(FINIT)) u0 (
    .wclk(clk), .wrst(rst), .ld_n(ld_n), .wen_n(wen_n), .din(din),
    .rclk(clk), .rrst(rst), .ren_n(ren_n), .mem_q(mem_q),
    .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .pae_valid(pae_valid), .paf_valid(paf_valid));

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // reference state
  logic [7:0] m_reg [6];
  int m_wp, m_rp;
  logic [7:0] m_dout;
  logic m_fd, m_ed;
  logic [1:0] m_fp, m_es;

  function automatic int nxt(int p);
    return (p == 5) ? 0 : p + 1;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit r, bit l, bit we, bit re,
                     logic [7:0] d, logic [7:0] q);
    logic [7:0] old [6];
    @(negedge clk);
    rst = r; ld_n = l; wen_n = we; ren_n = re; din = d; mem_q = q;
    @(posedge clk);
    if (!r && !l && !we && !re) begin
      fails++; checks++;
      $display("FAIL R9 offset write and read together actual=1 expected=0");
    end
    for (int i = 0; i < 6; i++) old[i] = m_reg[i];
    if (r) begin
      m_reg[0] = EINIT[7:0];  m_reg[1] = EINIT[15:8]; m_reg[2] = EINIT[23:16];
      m_reg[3] = FINIT[7:0];  m_reg[4] = FINIT[15:8]; m_reg[5] = FINIT[23:16];
      m_wp = 0; m_rp = 0; m_dout = '0; m_fd = 1; m_ed = 1; m_fp = '0; m_es = '0;
    end else begin
      m_fp = {m_fp[0], m_fd};
      m_es = {m_es[0], m_ed};
      if (!l && !we) begin
        m_reg[m_wp] = d;
        if (m_wp < 3) m_ed = (m_wp == 2);
        else          m_fd = (m_wp == 5);
        m_wp = nxt(m_wp);
      end
      if (!re) begin
        if (l) m_dout = q;
        else begin m_dout = old[m_rp]; m_rp = nxt(m_rp); end
      end
    end
    #1;
    chk(tag, "dout", 64'(dout), 64'(m_dout));
    chk(tag, "empty_ofs", 64'(empty_ofs), 64'({m_reg[2], m_reg[1], m_reg[0]}));
    chk(tag, "full_ofs", 64'(full_ofs), 64'({m_reg[5], m_reg[4], m_reg[3]}));
    chk(tag, "paf_valid", 64'(paf_valid), 64'(m_fp[1] & m_fd));
    chk(tag, "pae_valid", 64'(pae_valid), 64'(m_es[1]));
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #600000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    // R10: reset state and flags rising after release
    cyc("R10", 1, 1, 1, 1, 0, 0);
    cyc("R10", 1, 1, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R10", 0, 1, 1, 1, 0, 0);
    // R1, R7, R8: fill all six registers
    for (int i = 0; i < 6; i++) cyc("R1", 0, 0, 0, 1, 8'(8'h11 * (i + 1)), 0);
    for (int i = 0; i < 3; i++) cyc("R7", 0, 1, 1, 1, 0, 0);
    // R2: seventh write lands on empty LSB again
    cyc("R2", 0, 0, 0, 1, 8'h77, 0);
    for (int i = 0; i < 3; i++) cyc("R8", 0, 1, 1, 1, 0, 0);
    // R3 and R2: seven reads wrap
    for (int i = 0; i < 7; i++) cyc("R3", 0, 0, 1, 0, 0, 8'hEE);
    // R4: FIFO word, then offset read overwrites it
    cyc("R4", 0, 1, 1, 0, 0, 8'hA5);
    cyc("R4", 0, 0, 1, 0, 0, 8'h5A);
    // R5: pauses on both sides, then resume
    cyc("R5", 0, 0, 0, 1, 8'hC1, 0);
    cyc("R5", 0, 1, 0, 1, 8'hD2, 0);
    cyc("R5", 0, 0, 1, 1, 8'hD3, 0);
    cyc("R5", 0, 0, 0, 1, 8'hC4, 0);
    cyc("R5", 0, 0, 1, 1, 0, 0);
    cyc("R5", 0, 1, 1, 0, 0, 8'h3C);
    cyc("R5", 0, 0, 1, 0, 0, 0);
    // R6: reset mid-sequence restarts both pointers
    cyc("R6", 0, 0, 0, 1, 8'h99, 0);
    cyc("R6", 1, 1, 1, 1, 0, 0);
    cyc("R6", 0, 0, 0, 1, 8'hB0, 0);
    cyc("R6", 0, 1, 1, 1, 0, 0);
    cyc("R6", 0, 0, 1, 0, 0, 0);
    // random mix, never offset write with offset read (R9)
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] d, q;
      op = int'($urandom_range(0, 5));
      d = 8'($urandom);
      q = 8'($urandom);
      case (op)
        0: cyc("R1", 0, 0, 0, 1, d, q);
        1: cyc("R3", 0, 0, 1, 0, d, q);
        2: cyc("R5", 0, 1, 0, 1, d, q);
        3: cyc("R4", 0, 1, 1, 0, d, q);
        4: cyc("R5", 0, 0, 1, 1, d, q);
        default: cyc("R6", ($urandom_range(0, 99) == 0), 1, 1, 1, d, q);
      endcase
    end
    summary();
  end
endmodule